// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block is a watchdog timer that counts pulses of a slow oscillator enable, one pulse per oscillator period, presented in the system clock domain. A prescale counter divides these pulses by a fixed ratio (128 by default) to form a base period. A 20-stage binary postscaler then stretches the base period by a power of two that a 4-bit select code picks. When the chosen count is reached, the watchdog raises a one-cycle request. If the device is awake, that request is a reset. If the device is asleep, it is a wake-up.

A 2-bit static mode input and a software enable bit decide whether the timer runs. The timer can be off, running only while awake, under software control, or always running. Several system events return both counters to zero: a clear-watchdog strobe, a sleep-entry strobe, a change of the oscillator frequency select, and an active clock-fail flag. An output asks for the slow oscillator whenever the timer is effectively enabled.

Top module: `wdog_postscale`

## Requirements
- R1: After reset both request outputs are low, and the first timeout needs a full period.
- R2: With the timer enabled and the counters at zero, a request appears after exactly PRE_DIV * 2^sel oscillator ticks, where sel is the select code. Code 0 gives a ratio of 1.
- R3: Select codes above POST_STAGES saturate at a ratio of 2^POST_STAGES.
- R4: A request is one system cycle wide, and the counters restart from zero after each timeout, so the next request needs another full period.
- R5: Mode code 00 disables the timer. Mode code 11 enables it regardless of sleep state and software enable.
- R6: In mode code 10, sw_en_i high runs the timer and sw_en_i low stops it.
- R7: In mode code 01, the timer runs while asleep_i is low and is stopped while asleep_i is high.
- R8: A timeout with asleep_i high pulses wake_req_o and not rst_req_o. A timeout with asleep_i low pulses rst_req_o only.
- R9: A clear strobe, a sleep-entry strobe or an oscillator-select-change strobe is remembered until the next oscillator tick. That tick zeroes both counters instead of advancing them.
- R10: While clk_fail_i is high, every oscillator tick zeroes both counters.
- R11: A clear that coincides with the terminal tick of a period suppresses the request, and a full period follows.
- R12: lf_osc_req_o is high exactly when the effective enable is high.
- R13: A tick seen while the effective enable is low zeroes both counters, so counting restarts from zero after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lf_tick_i | input | 1 | One-cycle pulse per slow oscillator period |
| en_mode_i | input | 2 | Static enable mode: 00 off, 01 awake only, 10 software, 11 always |
| sw_en_i | input | 1 | Software enable, used in mode 10 |
| ps_sel_i | input | 4 | Postscaler select, ratio 2^code, saturating |
| clr_i | input | 1 | Clear-watchdog strobe |
| sleep_enter_i | input | 1 | Sleep-entry strobe |
| osc_chg_i | input | 1 | Oscillator frequency select change strobe |
| clk_fail_i | input | 1 | Clock failure flag, level |
| asleep_i | input | 1 | Device is in sleep or another power-managed state |
| rst_req_o | output | 1 | One-cycle reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| lf_osc_req_o | output | 1 | Request to run the slow oscillator |

## Verification
A clear and a timeout can land on the same oscillator tick. The bench counts up to one tick short of the period. It then raises the clear strobe in the same system cycle as the terminal tick. The test passes if neither request appears on that tick and the next request arrives only a full period later. The checker also asserts that any tick carrying a clear source produces no request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'b00,
    WD_AWAKE = 2'b01,
    WD_SOFT  = 2'b10,
    WD_ON    = 2'b11
  } wd_mode_e;
endpackage

// File: rtl/wdog_enable.sv
module wdog_enable
  import wdog_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       asleep_i,
  output logic       en_o
);
  wd_mode_e mode;
  assign mode = wd_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      WD_OFF:   en_o = 1'b0;
      WD_AWAKE: en_o = ~asleep_i;
      WD_SOFT:  en_o = sw_en_i;
      WD_ON:    en_o = 1'b1;
      default:  en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdog_clear_hold.sv
module wdog_clear_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic sleep_enter_i,
  input  logic osc_chg_i,
  input  logic clk_fail_i,
  output logic zero_o
);
  logic strobe;
  logic pend_q;

  assign strobe = clr_i | sleep_enter_i | osc_chg_i;

  // strobe held until the slow tick that applies it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (tick_i)  pend_q <= 1'b0;
    else if (strobe)  pend_q <= 1'b1;
  end

  assign zero_o = pend_q | strobe | clk_fail_i;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int PRE_DIV     = 128,
  parameter int POST_STAGES = 20,
  parameter int SEL_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int SH_W  = $clog2(POST_STAGES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0]       pre_q;
  logic [POST_STAGES-1:0] post_q;
  logic [SH_W-1:0]        sel_eff;
  logic [POST_STAGES-1:0] mask;
  logic                   pre_last;
  logic                   post_done;

  always_comb begin
    if (int'(sel_i) > POST_STAGES) sel_eff = SH_W'(POST_STAGES);
    else                           sel_eff = SH_W'(sel_i);
  end

  assign mask      = ~({POST_STAGES{1'b1}} << sel_eff);
  assign pre_last  = (pre_q == PRE_LAST);
  assign post_done = (post_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (tick_i) begin
      if (hold_i) begin
        pre_q  <= '0;
        post_q <= '0;
      end else if (pre_last) begin
        pre_q  <= '0;
        post_q <= post_done ? '0 : post_q + 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end

  assign hit_o = tick_i & ~hold_i & pre_last & post_done;
endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
  parameter int PRE_DIV     = 128,
  parameter int POST_STAGES = 20,
  parameter int SEL_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lf_tick_i,
  input  logic [1:0]       en_mode_i,
  input  logic             sw_en_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  input  logic             clr_i,
  input  logic             sleep_enter_i,
  input  logic             osc_chg_i,
  input  logic             clk_fail_i,
  input  logic             asleep_i,
  output logic             rst_req_o,
  output logic             wake_req_o,
  output logic             lf_osc_req_o
);
  logic en;
  logic zero_req;
  logic hit;
  logic rst_q, wake_q;

  wdog_enable u_enable (
    .mode_i  (en_mode_i),
    .sw_en_i (sw_en_i),
    .asleep_i(asleep_i),
    .en_o    (en)
  );

  wdog_clear_hold u_clear (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (lf_tick_i),
    .clr_i        (clr_i),
    .sleep_enter_i(sleep_enter_i),
    .osc_chg_i    (osc_chg_i),
    .clk_fail_i   (clk_fail_i),
    .zero_o       (zero_req)
  );

  wdog_counter #(
    .PRE_DIV    (PRE_DIV),
    .POST_STAGES(POST_STAGES),
    .SEL_W      (SEL_W)
  ) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(lf_tick_i),
    .hold_i(zero_req | ~en),
    .sel_i (ps_sel_i),
    .hit_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rst_q  <= hit & ~asleep_i;
      wake_q <= hit & asleep_i;
    end
  end

  assign rst_req_o    = rst_q;
  assign wake_req_o   = wake_q;
  assign lf_osc_req_o = en;
endmodule

// File: rtl/wdog_postscale_chk.sv
module wdog_postscale_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lf_tick_i,
  input logic [1:0] en_mode_i,
  input logic       clr_i,
  input logic       sleep_enter_i,
  input logic       osc_chg_i,
  input logic       clk_fail_i,
  input logic       asleep_i,
  input logic       rst_req_o,
  input logic       wake_req_o,
  input logic       lf_osc_req_o
);
  // R8
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && wake_req_o));

  // R4
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R4
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);

  // R2
  tick_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lf_tick_i |=> !(rst_req_o || wake_req_o));

  // R5
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mode_i == 2'b00) |=> !(rst_req_o || wake_req_o));

  // R13
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lf_osc_req_o |=> !(rst_req_o || wake_req_o));

  // R7
  awake_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mode_i == 2'b01 && asleep_i) |=> !wake_req_o);

  // R11
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lf_tick_i && (clr_i || sleep_enter_i || osc_chg_i || clk_fail_i))
      |=> !(rst_req_o || wake_req_o));
endmodule

bind wdog_postscale wdog_postscale_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lf_tick_i    (lf_tick_i),
  .en_mode_i    (en_mode_i),
  .clr_i        (clr_i),
  .sleep_enter_i(sleep_enter_i),
  .osc_chg_i    (osc_chg_i),
  .clk_fail_i   (clk_fail_i),
  .asleep_i     (asleep_i),
  .rst_req_o    (rst_req_o),
  .wake_req_o   (wake_req_o),
  .lf_osc_req_o (lf_osc_req_o)
);

// File: tb/wdog_postscale_bench.sv
module wdog_postscale_bench;
  localparam int PRE_DIV     = 4;
  localparam int POST_STAGES = 6;
  localparam int SEL_W       = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lf_tick_i = 1'b0;
  logic [1:0]       en_mode_i = 2'b11;
  logic             sw_en_i = 1'b0;
  logic [SEL_W-1:0] ps_sel_i = '0;
  logic             clr_i = 1'b0;
  logic             sleep_enter_i = 1'b0;
  logic             osc_chg_i = 1'b0;
  logic             clk_fail_i = 1'b0;
  logic             asleep_i = 1'b0;
  logic             rst_req_o, wake_req_o, lf_osc_req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdog_postscale #(
    .PRE_DIV(PRE_DIV), .POST_STAGES(POST_STAGES), .SEL_W(SEL_W)
  ) u_wdog_postscale (
    .clk_i(clk), .rst_ni(rst_ni), .lf_tick_i(lf_tick_i),
    .en_mode_i(en_mode_i), .sw_en_i(sw_en_i), .ps_sel_i(ps_sel_i),
    .clr_i(clr_i), .sleep_enter_i(sleep_enter_i), .osc_chg_i(osc_chg_i),
    .clk_fail_i(clk_fail_i), .asleep_i(asleep_i),
    .rst_req_o(rst_req_o), .wake_req_o(wake_req_o),
    .lf_osc_req_o(lf_osc_req_o)
  );

  function automatic int period(input int sel);
    int s;
    s = (sel > POST_STAGES) ? POST_STAGES : sel;
    return PRE_DIV << s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one slow tick; returns request outputs in the cycle after it
  task automatic tick_obs(output logic r, output logic w);
    @(negedge clk); lf_tick_i = 1'b1;
    @(negedge clk); lf_tick_i = 1'b0;
    r = rst_req_o; w = wake_req_o;
  endtask

  task automatic run_ticks(input int n, output int pulses);
    logic r, w;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      tick_obs(r, w);
      if (r || w) pulses++;
    end
  endtask

  task automatic to_pulse(input int limit, output int n, output logic was_wake);
    logic r, w;
    n = 0; was_wake = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      tick_obs(r, w);
      if (r || w) begin n = i; was_wake = w; break; end
    end
  endtask

  task automatic flush();
    logic r, w;
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    tick_obs(r, w);
  endtask

  task automatic t_reset();
    check(rst_req_o == 1'b0 && wake_req_o == 1'b0, "R1 outputs after reset",
          {rst_req_o, wake_req_o}, 0);
  endtask

  task automatic t_first_period();
    int n; logic w;
    ps_sel_i = 4'd1;
    to_pulse(4 * period(1), n, w);
    check(n == period(1), "R1 first timeout from reset", n, period(1));
  endtask

  task automatic t_periods();
    int n; logic w;
    for (int s = 0; s < 4; s++) begin
      ps_sel_i = SEL_W'(s);
      flush();
      to_pulse(4 * period(s), n, w);
      check(n == period(s), $sformatf("R2 period sel=%0d", s), n, period(s));
    end
  endtask

  task automatic t_saturate();
    int n; logic w;
    ps_sel_i = 4'd9;
    flush();
    to_pulse(4 * period(POST_STAGES), n, w);
    check(n == period(POST_STAGES), "R3 saturated ratio", n, period(POST_STAGES));
  endtask

  task automatic t_restart_width();
    int n; logic w;
    ps_sel_i = 4'd1;
    flush();
    to_pulse(4 * period(1), n, w);
    @(negedge clk);
    check(rst_req_o == 1'b0, "R4 request one cycle wide", rst_req_o, 0);
    to_pulse(4 * period(1), n, w);
    check(n == period(1), "R4 restart after timeout", n, period(1));
  endtask

  task automatic t_mode_off();
    int p;
    ps_sel_i = 4'd0;
    en_mode_i = 2'b00; sw_en_i = 1'b1;
    #1;
    check(lf_osc_req_o == 1'b0, "R12 osc request off in mode 00", lf_osc_req_o, 0);
    run_ticks(3 * period(0), p);
    check(p == 0, "R5 mode 00 no request", p, 0);
    en_mode_i = 2'b11; sw_en_i = 1'b0; asleep_i = 1'b0;
    #1;
    check(lf_osc_req_o == 1'b1, "R12 osc request on in mode 11", lf_osc_req_o, 1);
  endtask

  task automatic t_disable_restart();
    int p, n; logic w;
    ps_sel_i = 4'd1;
    flush();
    run_ticks(period(1) - 1, p);
    en_mode_i = 2'b00;
    run_ticks(1, p);
    en_mode_i = 2'b11;
    to_pulse(4 * period(1), n, w);
    check(n == period(1), "R13 count restarts after disable", n, period(1));
  endtask

  task automatic t_soft();
    int p, n; logic w;
    ps_sel_i = 4'd0;
    en_mode_i = 2'b10; sw_en_i = 1'b0;
    flush();
    run_ticks(3 * period(0), p);
    check(p == 0, "R6 software enable low", p, 0);
    check(lf_osc_req_o == 1'b0, "R12 osc request follows sw enable", lf_osc_req_o, 0);
    sw_en_i = 1'b1;
    to_pulse(4 * period(0), n, w);
    check(n == period(0), "R6 software enable high", n, period(0));
    en_mode_i = 2'b11; sw_en_i = 1'b0;
  endtask

  task automatic t_awake_only();
    int p, n; logic w;
    ps_sel_i = 4'd0;
    en_mode_i = 2'b01; asleep_i = 1'b1;
    flush();
    run_ticks(3 * period(0), p);
    check(p == 0, "R7 mode 01 stopped asleep", p, 0);
    asleep_i = 1'b0;
    to_pulse(4 * period(0), n, w);
    check(n == period(0) && !w, "R7 mode 01 runs awake", n, period(0));
    en_mode_i = 2'b11;
  endtask

  task automatic t_sleep_wake();
    int n; logic w;
    ps_sel_i = 4'd0;
    asleep_i = 1'b1;
    flush();
    to_pulse(4 * period(0), n, w);
    check(n == period(0), "R8 timeout while asleep", n, period(0));
    check(w == 1'b1, "R8 wake not reset", w, 1);
    asleep_i = 1'b0;
  endtask

  task automatic t_clear_sources();
    int p, n; logic w;
    ps_sel_i = 4'd1;
    for (int k = 0; k < 3; k++) begin
      flush();
      run_ticks(period(1) - 1, p);
      @(negedge clk);
      clr_i = (k == 0); sleep_enter_i = (k == 1); osc_chg_i = (k == 2);
      @(negedge clk);
      clr_i = 1'b0; sleep_enter_i = 1'b0; osc_chg_i = 1'b0;
      repeat (3) @(negedge clk);
      run_ticks(1, p);
      check(p == 0, $sformatf("R9 held clear src %0d", k), p, 0);
      to_pulse(4 * period(1), n, w);
      check(n == period(1), $sformatf("R9 full period after src %0d", k), n, period(1));
    end
  endtask

  task automatic t_clk_fail();
    int p, n; logic w;
    ps_sel_i = 4'd0;
    flush();
    run_ticks(period(0) - 1, p);
    clk_fail_i = 1'b1;
    run_ticks(3 * period(0), p);
    check(p == 0, "R10 clock fail holds counters", p, 0);
    clk_fail_i = 1'b0;
    to_pulse(4 * period(0), n, w);
    check(n == period(0), "R10 full period after clock fail", n, period(0));
  endtask

  task automatic t_collision();
    int p, n; logic w;
    ps_sel_i = 4'd1;
    flush();
    run_ticks(period(1) - 1, p);
    @(negedge clk); lf_tick_i = 1'b1; clr_i = 1'b1;
    @(negedge clk); lf_tick_i = 1'b0; clr_i = 1'b0;
    check(!rst_req_o && !wake_req_o, "R11 clear beats timeout", rst_req_o, 0);
    to_pulse(4 * period(1), n, w);
    check(n == period(1), "R11 full period after collision", n, period(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_period();
    t_periods();
    t_saturate();
    t_restart_width();
    t_mode_off();
    t_disable_restart();
    t_soft();
    t_awake_only();
    t_sleep_wake();
    t_clear_sources();
    t_clk_fail();
    t_collision();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule